// File: doc/BRIEF.md
# String Element Sequencer

This block runs one element of a repeatable string instruction in a 16-bit core. The five kinds are block move, compare, store, load and scan. The core pulses `start` with an operation code, the element size, the direction flag, the two repeat flags from its prefix logic and the current CX, SI and DI values. The sequencer then does four things:

- It raises the memory and compare strobes for that operation in the first busy cycle.
- It waits a fixed number of cycles, which depends on the operation.
- It samples the ALU zero flag in the last busy cycle.
- It returns the stepped pointers and the new count, together with a one-cycle `done` pulse.

Repetition is not a loop inside the block. When another pass is due, the block raises `ip_rewind` and `hold` in the `done` cycle. The core then moves its instruction pointer back by one byte, keeps its prefix state and fetches the same instruction again. Compare and scan can end a repeated run early on the zero-flag condition. The memory bus, the ALU and instruction fetch are outside the block.

Top module: `strop_sequencer`

## Requirements
- R1: Operation codes are 0 move, 1 compare, 2 store, 3 load, 4 scan. The block accepts a `start` when it is idle and the code is 0 to 4, and `busy` is high in the next cycle. A `start` with code 5, 6 or 7 is ignored: neither `busy` nor `done` rises.
- R2: `busy` stays high for W cycles after the accepting edge, and `done` is then high for exactly one cycle. W is 4 for move, 5 for compare, 2 for store, 2 for load and 3 for scan.
- R3: A `start` that arrives while `busy` is high is ignored. The running element finishes with its own latched inputs, and no extra `done` follows.
- R4: The step is 1 when `word_sel`=0 and 2 when `word_sel`=1. It is added when `dir_dn`=0 and subtracted when `dir_dn`=1, modulo 2^16. SI steps for move, compare and load. DI steps for move, compare, store and scan. A pointer that an operation does not use comes back unchanged.
- R5: In the first busy cycle only, the block pulses the following strobes:
  - `rd_src` (read at DS:SI) for move, compare and load;
  - `rd_dst` (read at ES:DI) for compare and scan;
  - `wr_dst` (write at ES:DI) for move and store;
  - `cmp_strobe` for compare and scan.
- R6: When both repeat flags are clear, the element runs once: `cx_out` equals the CX given at start, and `ip_rewind` and `hold` stay low.
- R7: When a repeat flag is set and no early stop applies, `cx_out` is CX-1. If that value is nonzero, `ip_rewind` and `hold` are high during the `done` cycle and only then.
- R8: A repeated element that starts with CX=0 wraps the count to 0xFFFF and requests another pass.
- R9: For compare and scan, the zero flag is sampled in the last busy cycle. With `rep_nz` set and the zero flag 1, or `rep_z` set and the zero flag 0, the run stops: CX is not decremented, and there is no rewind and no hold.
- R10: Move, store and load ignore the zero flag. Their count and repeat decision depend only on the repeat flags and CX.
- R11: After reset, `busy`, `done`, every strobe, `ip_rewind` and `hold` are low, and `cx_out`, `si_out` and `di_out` are 0.
- R12: `cx_out`, `si_out` and `di_out` change only on the edge that raises `done`, and they hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one element |
| op_sel | input | 3 | Operation code (see R1) |
| word_sel | input | 1 | 1 = word elements, 0 = byte elements |
| dir_dn | input | 1 | Direction flag; 1 = pointers decrease |
| rep_nz | input | 1 | Repeat while not zero |
| rep_z | input | 1 | Repeat while zero |
| zf | input | 1 | Zero flag from the ALU compare |
| cx_in | input | 16 | Count at start |
| si_in | input | 16 | Source pointer at start |
| di_in | input | 16 | Destination pointer at start |
| busy | output | 1 | Element in progress |
| rd_src | output | 1 | Read request at DS:SI |
| rd_dst | output | 1 | Read request at ES:DI |
| wr_dst | output | 1 | Write request at ES:DI |
| cmp_strobe | output | 1 | The ALU should subtract and set flags |
| done | output | 1 | One-cycle end-of-element pulse |
| ip_rewind | output | 1 | Move the instruction pointer back one byte |
| hold | output | 1 | Keep the prefix state for the next pass |
| cx_out | output | 16 | Updated count |
| si_out | output | 16 | Updated source pointer |
| di_out | output | 16 | Updated destination pointer |

## Verification
Latched context is the main internal state. A corrupted operation code, size or direction shows up on the first busy cycle as a wrong strobe. The same fault then shows up W cycles later as a wrong pointer step. A fault in the wait counter shows as `done` arriving early or late in the same element. A wrong repeat decision is seen in the `done` cycle as a wrong `cx_out` or a missing or extra `hold`. Random elements with low counts and random zero flags reach the stop, wrap and last-pass cases often.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_STORE = 3'd2,
        OP_LOAD  = 3'd3,
        OP_SCAN  = 3'd4
    } str_op_e;

    // What each operation touches
    typedef struct packed {
        logic adv_si;
        logic adv_di;
        logic rd_src;
        logic rd_dst;
        logic wr_dst;
        logic compare;
    } op_attr_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic op_attr_t op_attr(input logic [2:0] code);
        op_attr_t a;
        a = '0;
        case (str_op_e'(code))
            OP_MOVE:  begin a.adv_si = 1'b1; a.adv_di = 1'b1; a.rd_src = 1'b1; a.wr_dst = 1'b1; end
            OP_CMP:   begin a.adv_si = 1'b1; a.adv_di = 1'b1; a.rd_src = 1'b1; a.rd_dst = 1'b1; a.compare = 1'b1; end
            OP_STORE: begin a.adv_di = 1'b1; a.wr_dst = 1'b1; end
            OP_LOAD:  begin a.adv_si = 1'b1; a.rd_src = 1'b1; end
            OP_SCAN:  begin a.adv_di = 1'b1; a.rd_dst = 1'b1; a.compare = 1'b1; end
            default:  a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/strseq_timer.sv
module strseq_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CW'(1));

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt_q == '0)); // R3

endmodule

// File: rtl/strseq_step.sv
module strseq_step #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] ptr_in,
    input  logic          adv,
    input  logic          word,
    input  logic          dir_dn,
    output logic [DW-1:0] ptr_out
);
    logic [DW-1:0] step;

    always_comb begin
        step = word ? DW'(2) : DW'(1);
        if (!adv)
            ptr_out = ptr_in;
        else if (dir_dn)
            ptr_out = ptr_in - step;
        else
            ptr_out = ptr_in + step;
    end
endmodule

// File: rtl/strseq_repeat.sv
module strseq_repeat #(
    parameter int DW = 16
) (
    input  logic          rep_nz,
    input  logic          rep_z,
    input  logic          compare,
    input  logic          zf,
    input  logic [DW-1:0] cx_in,
    output logic [DW-1:0] cx_out,
    output logic          again
);
    logic          early_stop;
    logic [DW-1:0] cx_dec;

    always_comb begin
        early_stop = compare && ((rep_nz && zf) || (rep_z && !zf));
        cx_dec     = cx_in - 1'b1;
        if (!(rep_nz || rep_z) || early_stop) begin
            cx_out = cx_in;
            again  = 1'b0;
        end else begin
            cx_out = cx_dec;
            again  = (cx_dec != '0);
        end
    end
endmodule

// File: rtl/strop_sequencer.sv
module strop_sequencer
    import strseq_pkg::*;
#(
    parameter int DW          = 16,
    parameter int WAIT_MOVE   = 4,
    parameter int WAIT_CMP    = 5,
    parameter int WAIT_STORE  = 2,
    parameter int WAIT_LOAD   = 2,
    parameter int WAIT_SCAN   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_sel,
    input  logic          word_sel,
    input  logic          dir_dn,
    input  logic          rep_nz,
    input  logic          rep_z,
    input  logic          zf,
    input  logic [DW-1:0] cx_in,
    input  logic [DW-1:0] si_in,
    input  logic [DW-1:0] di_in,
    output logic          busy,
    output logic          rd_src,
    output logic          rd_dst,
    output logic          wr_dst,
    output logic          cmp_strobe,
    output logic          done,
    output logic          ip_rewind,
    output logic          hold,
    output logic [DW-1:0] cx_out,
    output logic [DW-1:0] si_out,
    output logic [DW-1:0] di_out
);
    localparam int WMAX_A = (WAIT_MOVE  > WAIT_CMP)  ? WAIT_MOVE  : WAIT_CMP;
    localparam int WMAX_B = (WAIT_STORE > WAIT_LOAD) ? WAIT_STORE : WAIT_LOAD;
    localparam int WMAX_C = (WMAX_A > WMAX_B) ? WMAX_A : WMAX_B;
    localparam int WMAX   = (WMAX_C > WAIT_SCAN) ? WMAX_C : WAIT_SCAN;
    localparam int CW     = $clog2(WMAX + 1);
    localparam int NPTR   = 2;

    typedef struct packed {
        op_attr_t      attr;
        logic          word;
        logic          dir;
        logic          rnz;
        logic          rz;
        logic [DW-1:0] cx;
        logic [DW-1:0] si;
        logic [DW-1:0] di;
    } ctx_t;

    typedef struct packed {
        logic          done;
        logic          again;
        logic          rd_src;
        logic          rd_dst;
        logic          wr_dst;
        logic          cmp;
        logic [DW-1:0] cx;
        logic [DW-1:0] si;
        logic [DW-1:0] di;
    } out_t;

    ctx_t ctx_d, ctx_q;
    out_t out_d, out_q;

    logic          accept;
    logic [CW-1:0] wait_sel;
    logic          tmr_busy, tmr_last;
    logic [DW-1:0] cx_next;
    logic          again_next;
    logic [DW-1:0] ptr_in  [NPTR];
    logic [DW-1:0] ptr_out [NPTR];
    logic          ptr_adv [NPTR];

    // Wait count for the requested operation
    always_comb begin
        case (str_op_e'(op_sel))
            OP_MOVE:  wait_sel = CW'(WAIT_MOVE);
            OP_CMP:   wait_sel = CW'(WAIT_CMP);
            OP_STORE: wait_sel = CW'(WAIT_STORE);
            OP_LOAD:  wait_sel = CW'(WAIT_LOAD);
            OP_SCAN:  wait_sel = CW'(WAIT_SCAN);
            default:  wait_sel = '0;
        endcase
    end

    assign accept = start && !tmr_busy && op_known(op_sel);

    strseq_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_sel),
        .busy     (tmr_busy),
        .last     (tmr_last)
    );

    assign ptr_in[0]  = ctx_q.si;
    assign ptr_in[1]  = ctx_q.di;
    assign ptr_adv[0] = ctx_q.attr.adv_si;
    assign ptr_adv[1] = ctx_q.attr.adv_di;

    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        strseq_step #(.DW(DW)) i_step (
            .ptr_in  (ptr_in[gi]),
            .adv     (ptr_adv[gi]),
            .word    (ctx_q.word),
            .dir_dn  (ctx_q.dir),
            .ptr_out (ptr_out[gi])
        );
    end

    strseq_repeat #(.DW(DW)) i_repeat (
        .rep_nz  (ctx_q.rnz),
        .rep_z   (ctx_q.rz),
        .compare (ctx_q.attr.compare),
        .zf      (zf),
        .cx_in   (ctx_q.cx),
        .cx_out  (cx_next),
        .again   (again_next)
    );

    always_comb begin
        ctx_d = ctx_q;
        out_d = out_q;
        out_d.done   = 1'b0;
        out_d.again  = 1'b0;
        out_d.rd_src = 1'b0;
        out_d.rd_dst = 1'b0;
        out_d.wr_dst = 1'b0;
        out_d.cmp    = 1'b0;
        if (accept) begin
            ctx_d.attr = op_attr(op_sel);
            ctx_d.word = word_sel;
            ctx_d.dir  = dir_dn;
            ctx_d.rnz  = rep_nz;
            ctx_d.rz   = rep_z;
            ctx_d.cx   = cx_in;
            ctx_d.si   = si_in;
            ctx_d.di   = di_in;
            out_d.rd_src = ctx_d.attr.rd_src;
            out_d.rd_dst = ctx_d.attr.rd_dst;
            out_d.wr_dst = ctx_d.attr.wr_dst;
            out_d.cmp    = ctx_d.attr.compare;
        end
        if (tmr_last) begin
            out_d.done  = 1'b1;
            out_d.again = again_next;
            out_d.cx    = cx_next;
            out_d.si    = ptr_out[0];
            out_d.di    = ptr_out[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
            out_q <= '0;
        end else begin
            ctx_q <= ctx_d;
            out_q <= out_d;
        end
    end

    assign busy       = tmr_busy;
    assign rd_src     = out_q.rd_src;
    assign rd_dst     = out_q.rd_dst;
    assign wr_dst     = out_q.wr_dst;
    assign cmp_strobe = out_q.cmp;
    assign done       = out_q.done;
    assign ip_rewind  = out_q.again;
    assign hold       = out_q.again;
    assign cx_out     = out_q.cx;
    assign si_out     = out_q.si;
    assign di_out     = out_q.di;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_sel <= 3'd4) |=> busy); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R2
    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src || rd_dst || wr_dst || cmp_strobe) |-> busy); // R5
    AST_CMP_READS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe |-> (rd_dst && !wr_dst)); // R5
    AST_HOLD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> done); // R7
    AST_HOLD_NONZERO_CX: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (cx_out != '0)); // R7
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cx_out) && $stable(si_out) && $stable(di_out))); // R12

endmodule

// File: tb/test_strop_sequencer.sv
module test_strop_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        word_sel = 1'b0, dir_dn = 1'b0, rep_nz = 1'b0, rep_z = 1'b0, zf = 1'b0;
    logic [15:0] cx_in = '0, si_in = '0, di_in = '0;
    logic        busy, rd_src, rd_dst, wr_dst, cmp_strobe, done, ip_rewind, hold;
    logic [15:0] cx_out, si_out, di_out;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    strop_sequencer i_strop_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .word_sel(word_sel),
        .dir_dn(dir_dn), .rep_nz(rep_nz), .rep_z(rep_z), .zf(zf),
        .cx_in(cx_in), .si_in(si_in), .di_in(di_in),
        .busy(busy), .rd_src(rd_src), .rd_dst(rd_dst), .wr_dst(wr_dst),
        .cmp_strobe(cmp_strobe), .done(done), .ip_rewind(ip_rewind), .hold(hold),
        .cx_out(cx_out), .si_out(si_out), .di_out(di_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic int exp_wait(input logic [2:0] op);
        case (op)
            3'd0: return 4;
            3'd1: return 5;
            3'd2: return 2;
            3'd3: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [15:0] exp_ptr(input logic [15:0] p, input bit adv, input bit w, input bit d);
        logic [15:0] s;
        s = w ? 16'd2 : 16'd1;
        if (!adv) return p;
        return d ? p - s : p + s;
    endfunction

    // returns {again, cx}
    function automatic logic [16:0] exp_rep(input logic [2:0] op, input bit nz, input bit z,
                                            input bit f, input logic [15:0] cx);
        bit cmpop;
        logic [15:0] dec;
        cmpop = (op == 3'd1) || (op == 3'd4);
        if (!(nz || z)) return {1'b0, cx};
        if (cmpop && ((nz && f) || (z && !f))) return {1'b0, cx};
        dec = cx - 16'd1;
        return {dec != 16'd0, dec};
    endfunction

    task automatic run_elem(input logic [2:0] op, input bit w, input bit d, input bit nz,
                            input bit z, input bit f, input logic [15:0] cx,
                            input logic [15:0] si, input logic [15:0] di, input bit poke);
        int k;
        int wt;
        bit adv_si, adv_di;
        logic [16:0] rep;
        wt = exp_wait(op);
        adv_si = (op == 3'd0) || (op == 3'd1) || (op == 3'd3);
        adv_di = (op != 3'd3);
        rep = exp_rep(op, nz, z, f, cx);
        @(negedge clk);
        op_sel = op; word_sel = w; dir_dn = d; rep_nz = nz; rep_z = z; zf = f;
        cx_in = cx; si_in = si; di_in = di; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after accept", busy, 1);
        chk(rd_src == adv_si && (op != 3'd3 || rd_src), "R5 rd_src", rd_src, adv_si);
        chk(rd_dst == (op == 3'd1 || op == 3'd4), "R5 rd_dst", rd_dst, (op == 3'd1 || op == 3'd4));
        chk(wr_dst == (op == 3'd0 || op == 3'd2), "R5 wr_dst", wr_dst, (op == 3'd0 || op == 3'd2));
        chk(cmp_strobe == (op == 3'd1 || op == 3'd4), "R5 cmp_strobe", cmp_strobe, (op == 3'd1 || op == 3'd4));
        k = 0;
        while (!done && k < 20) begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                chk(!(rd_src || rd_dst || wr_dst || cmp_strobe), "R5 strobes one cycle",
                    {rd_src, rd_dst, wr_dst, cmp_strobe}, 0);
                if (poke) begin
                    start = 1'b1; op_sel = 3'd3; si_in = ~si; cx_in = 16'h0;
                    rep_nz = 1'b0; rep_z = 1'b0;
                end
            end else if (k == 2 && poke) begin
                start = 1'b0;
            end
        end
        chk(k == wt, "R2 wait count", k, wt);
        chk(busy == 1'b0, "R2 idle at done", busy, 0);
        chk(si_out == exp_ptr(si, adv_si, w, d), "R4 si_out", si_out, exp_ptr(si, adv_si, w, d));
        chk(di_out == exp_ptr(di, adv_di, w, d), "R4 di_out", di_out, exp_ptr(di, adv_di, w, d));
        chk(cx_out == rep[15:0], "R7 R9 cx_out", cx_out, rep[15:0]);
        chk(hold == rep[16] && ip_rewind == rep[16], "R6 R7 hold/rewind", {hold, ip_rewind}, {2{rep[16]}});
        @(negedge clk);
        chk(done == 1'b0 && hold == 1'b0, "R2 done pulse", {done, hold}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("watchdog expired");
        checks++;
        fails++;
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && hold == 0 && ip_rewind == 0, "R11 reset controls",
            {busy, done, hold, ip_rewind}, 0);
        chk(cx_out == 0 && si_out == 0 && di_out == 0, "R11 reset values", {cx_out, si_out, di_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!(rd_src || rd_dst || wr_dst || cmp_strobe), "R11 reset strobes",
            {rd_src, rd_dst, wr_dst, cmp_strobe}, 0);

        // R1: unknown codes ignored
        for (int c = 5; c < 8; c++) begin
            @(negedge clk);
            op_sel = 3'(c); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 0, "R1 unknown code no busy", busy, 0);
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                chk(done == 0, "R1 unknown code no done", done, 0);
            end
        end

        // Directed corner cases
        run_elem(3'd0, 0, 0, 0, 0, 0, 16'd7, 16'h1000, 16'h2000, 0);   // R6 move once
        run_elem(3'd2, 1, 1, 1, 0, 1, 16'd0, 16'h0, 16'h0001, 0);       // R8 wrap, R10 zf ignored
        run_elem(3'd3, 0, 1, 0, 1, 0, 16'd1, 16'h0000, 16'h5555, 0);    // R7 last pass, R10, R4 wrap
        run_elem(3'd1, 1, 0, 1, 0, 1, 16'd9, 16'hFFFF, 16'hFFFE, 0);    // R9 repnz stop
        run_elem(3'd4, 0, 0, 0, 1, 0, 16'd9, 16'h1234, 16'h4321, 0);    // R9 repz stop
        run_elem(3'd4, 1, 1, 0, 1, 1, 16'd9, 16'h1234, 16'h0000, 0);    // R7 scan continues
        run_elem(3'd0, 1, 0, 1, 0, 1, 16'd3, 16'h00FF, 16'h0100, 0);    // R10 move ignores zf

        // R3: start during busy
        run_elem(3'd1, 0, 0, 0, 0, 0, 16'd4, 16'h0040, 16'h0080, 1);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            chk(done == 0 && busy == 0, "R3 no extra element", {done, busy}, 0);
        end
        // R12: outputs held between elements
        chk(si_out == 16'h0041 && cx_out == 16'd4, "R12 outputs held", {si_out, cx_out}, {16'h0041, 16'd4});

        // Random elements
        for (int n = 0; n < 300; n++) begin
            logic [15:0] rcx;
            int sel;
            sel = $urandom % 4;
            rcx = (sel == 0) ? 16'(($urandom % 3)) : 16'($urandom);
            run_elem(3'($urandom % 5), 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), rcx,
                     (sel == 1) ? 16'hFFFF : 16'($urandom), (sel == 2) ? 16'h0000 : 16'($urandom), 0);
        end
        finish_run();
    end
endmodule